// File: doc/BRIEF.md
# Periodic Autopoll Scheduler

This block decides when a serial input-device bus controller should be polled without being asked. A command path sets three values: an on/off flag, a poll interval in whole milliseconds, and a 16-bit mask that selects the device addresses to poll. While polling is on, a millisecond countdown runs. Each time it runs out, the block asks the bus controller for one poll, passing the mask along. If that poll returns bytes, the block asks the response path to send an unsolicited packet. The packet opens with a type byte of 0x00 and a flag byte of 0x40, and the returned bytes follow.

A prescaler divides the system clock into a 1 ms tick. The poll request is a level that stays high until the controller pulses a done strobe together with a byte count. The packet request works the same way: it stays high until the response path acknowledges it. The bus transaction and the transport of the packet bytes belong to neighbouring blocks.

Top module: `autopoll_sched`

## Requirements
- R1: After reset, polling is off, the interval is DEF_PERIOD_MS milliseconds, the mask is 0xFFFF (poll_mask reads 0xFFFF), and neither poll_req nor pkt_req is high.
- R2: An enable command whose byte is nonzero, received while polling is off, turns polling on and restarts the countdown. The first poll_req then rises exactly interval × CLK_PER_MS clock cycles after the command edge.
- R3: An enable command with a nonzero byte, received while polling is already on, does not restart the countdown. The poll schedule is unchanged.
- R4: An enable command with byte 0x00 turns polling off. No poll_req is raised while polling is off.
- R5: A rate command with a byte from 1 to 255 sets the interval to that many milliseconds. If polling is on, the countdown restarts with the new interval. If polling is off, the value is only stored and is used once polling is turned on.
- R6: A rate command with byte 0x00 is ignored. It changes neither the interval nor the current countdown.
- R7: A mask command loads the mask as {mask_cmd_hi, mask_cmd_lo}, with hi as bits 15:8. Each poll presents the mask as it stood at launch on poll_mask, and poll_mask holds steady while poll_req is high.
- R8: When a poll completes with a nonzero count N, pkt_req rises on the next cycle with pkt_type = 0x00, pkt_flag = 0x40 and pkt_len = N + 2. pkt_req and pkt_len hold until pkt_ack.
- R9: A poll that completes with a count of zero produces no packet.
- R10: Every expiry rearms the countdown for one full interval, whether or not the poll returns data. An expiry that arrives while a poll or a packet is still outstanding raises no new poll_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_cmd_vld | input | 1 | Enable command strobe |
| en_cmd_byte | input | 8 | Enable argument; nonzero turns polling on |
| rate_cmd_vld | input | 1 | Rate command strobe |
| rate_cmd_byte | input | 8 | Interval in ms; 0 is rejected |
| mask_cmd_vld | input | 1 | Mask command strobe |
| mask_cmd_hi | input | 8 | Mask bits 15:8 |
| mask_cmd_lo | input | 8 | Mask bits 7:0 |
| poll_req | output | 1 | Poll request, held until poll_done |
| poll_mask | output | 16 | Device mask sent with the poll |
| poll_done | input | 1 | Poll finished strobe |
| poll_count | input | CNT_W | Bytes returned by the poll |
| pkt_req | output | 1 | Packet send request, held until pkt_ack |
| pkt_type | output | 8 | First header byte (0x00) |
| pkt_flag | output | 8 | Second header byte (0x40) |
| pkt_len | output | CNT_W+1 | Total packet length, header included |
| pkt_ack | input | 1 | Packet accepted strobe |

## Verification
The bench builds the block with CLK_PER_MS = 4 and keeps the default interval of 20 ms. With these values one millisecond is four cycles, so the default interval, a 3 ms and a 5 ms interval, and even the 255 ms maximum (1020 cycles) all fit inside a short run. The short interval also lets an expiry fall inside a packet that is deliberately held unacknowledged, which exercises the dropped-expiry case. Poll start times are measured to the exact cycle, so they show whether each command restarted the countdown or left it alone.

// File: rtl/autopoll_pkg.sv
// Shared constants and types for the autopoll scheduler.
// Assumes byte-wide command arguments and a two-byte device mask.
package autopoll_pkg;
    localparam int BYTE_W = 8;
    localparam int MASK_W = 2 * BYTE_W;
    localparam logic [BYTE_W-1:0] HDR_TYPE_POLLED = 8'h00;
    localparam logic [BYTE_W-1:0] HDR_FLAG_POLLED = 8'h40;

    typedef enum logic [1:0] {
        AP_IDLE = 2'd0,
        AP_POLL = 2'd1,
        AP_SEND = 2'd2
    } ap_state_t;
endpackage

// File: rtl/ap_ms_tick.sv
// Millisecond prescaler: pulses tick once every CLK_PER_MS cycles while run is high.
// Assumes restart realigns the phase so that a full millisecond follows it.
module ap_ms_tick #(
    parameter int CLK_PER_MS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int PW = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
    localparam logic [PW-1:0] LAST = PW'(CLK_PER_MS - 1);

    logic [PW-1:0] cnt_q;

    // Tick on the last cycle of each millisecond.
    assign tick = run && (cnt_q == LAST);

    // Cycle counter, cleared on reset, restart, stop and wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + PW'(1);
        end
    end
endmodule

// File: rtl/ap_config.sv
// Command decoder and configuration registers: enable flag, interval, device mask.
// Assumes at most one strobe per command kind per cycle; strobes of different kinds may coincide.
module ap_config
    import autopoll_pkg::*;
#(
    parameter int DEF_PERIOD_MS = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_cmd_vld,
    input  logic [BYTE_W-1:0] en_cmd_byte,
    input  logic              rate_cmd_vld,
    input  logic [BYTE_W-1:0] rate_cmd_byte,
    input  logic              mask_cmd_vld,
    input  logic [BYTE_W-1:0] mask_cmd_hi,
    input  logic [BYTE_W-1:0] mask_cmd_lo,
    output logic              enable,
    output logic              restart,
    output logic [BYTE_W-1:0] reload,
    output logic [MASK_W-1:0] mask
);
    logic              en_q;
    logic [BYTE_W-1:0] period_q;
    logic [MASK_W-1:0] mask_q;
    logic              en_nxt;
    logic              rate_ok;

    // Next-state decode of the enable flag and the rate acceptance.
    always_comb begin
        en_nxt  = en_cmd_vld ? (en_cmd_byte != '0) : en_q;
        rate_ok = rate_cmd_vld && (rate_cmd_byte != '0);
        restart = (en_nxt && !en_q) || (rate_ok && en_nxt);
        reload  = rate_ok ? rate_cmd_byte : period_q;
    end

    // Configuration registers with their power-up values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            period_q <= BYTE_W'(DEF_PERIOD_MS);
            mask_q   <= '1;
        end else begin
            en_q <= en_nxt;
            if (rate_ok) begin
                period_q <= rate_cmd_byte;
            end
            if (mask_cmd_vld) begin
                mask_q <= {mask_cmd_hi, mask_cmd_lo};
            end
        end
    end

    assign enable = en_q;
    assign mask   = mask_q;

    // A zero rate leaves the stored interval alone (R6).
    assert_zero_rate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_cmd_vld && rate_cmd_byte == '0) |=> $stable(period_q));
endmodule

// File: rtl/ap_period_timer.sv
// Interval countdown in milliseconds; raises expire on the tick that ends an interval.
// Assumes reload is never zero and reflects any rate written in the same cycle.
module ap_period_timer
    import autopoll_pkg::*;
#(
    parameter int DEF_PERIOD_MS = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              restart,
    input  logic              tick,
    input  logic [BYTE_W-1:0] reload,
    output logic              expire
);
    logic [BYTE_W-1:0] remain_q;

    // Expiry on the final millisecond of the interval.
    assign expire = run && tick && (remain_q == BYTE_W'(1));

    // Countdown: load on restart, rearm on expiry, decrement on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= BYTE_W'(DEF_PERIOD_MS);
        end else if (restart || expire) begin
            remain_q <= reload;
        end else if (run && tick) begin
            remain_q <= remain_q - BYTE_W'(1);
        end
    end

    // A restart loads the full interval (R2, R5).
    assert_restart_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> remain_q == $past(reload));
    // The countdown never holds zero, since zero rates never reach it (R6).
    assert_no_zero_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        remain_q != '0);
endmodule

// File: rtl/ap_poll_fsm.sv
// Poll and packet sequencer: launches a poll per expiry, forwards data-bearing results.
// Assumes poll_done and pkt_ack are single-cycle strobes that answer an outstanding request.
module ap_poll_fsm
    import autopoll_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              expire,
    input  logic [MASK_W-1:0] mask,
    output logic              poll_req,
    output logic [MASK_W-1:0] poll_mask,
    input  logic              poll_done,
    input  logic [CNT_W-1:0]  poll_count,
    output logic              pkt_req,
    output logic [CNT_W:0]    pkt_len,
    input  logic              pkt_ack
);
    localparam int LEN_W = CNT_W + 1;

    ap_state_t         state_q;
    logic [MASK_W-1:0] mask_q;
    logic [LEN_W-1:0]  len_q;

    // Sequencer: idle, poll outstanding, packet outstanding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= AP_IDLE;
            mask_q  <= '1;
            len_q   <= '0;
        end else begin
            case (state_q)
                AP_IDLE: if (expire) begin
                    state_q <= AP_POLL;
                    mask_q  <= mask;
                end
                AP_POLL: if (poll_done) begin
                    if (poll_count != '0) begin
                        len_q   <= LEN_W'(poll_count) + LEN_W'(2);
                        state_q <= AP_SEND;
                    end else begin
                        state_q <= AP_IDLE;
                    end
                end
                AP_SEND: if (pkt_ack) begin
                    state_q <= AP_IDLE;
                end
                default: state_q <= AP_IDLE;
            endcase
        end
    end

    assign poll_req  = (state_q == AP_POLL);
    assign pkt_req   = (state_q == AP_SEND);
    assign poll_mask = mask_q;
    assign pkt_len   = len_q;

    // Poll request and its mask hold until done (R7).
    assert_poll_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_req && !poll_done) |=> (poll_req && $stable(poll_mask)));
    // Packet request and length hold until accepted (R8).
    assert_pkt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_req && !pkt_ack) |=> (pkt_req && $stable(pkt_len)));
    // An empty poll yields no packet (R9).
    assert_empty_poll_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_req && poll_done && poll_count == '0) |=> !pkt_req);
    // An expiry during an open packet starts no poll (R10).
    assert_drop_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_req && !pkt_ack && expire) |=> !poll_req);
endmodule

// File: rtl/autopoll_sched.sv
// Top of the autopoll scheduler: config registers, ms prescaler, countdown, sequencer.
// Assumes command strobes are single-cycle and that neighbours follow the req/done handshakes.
module autopoll_sched
    import autopoll_pkg::*;
#(
    parameter int CLK_PER_MS    = 1000,
    parameter int DEF_PERIOD_MS = 20,
    parameter int CNT_W         = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_cmd_vld,
    input  logic [7:0]        en_cmd_byte,
    input  logic              rate_cmd_vld,
    input  logic [7:0]        rate_cmd_byte,
    input  logic              mask_cmd_vld,
    input  logic [7:0]        mask_cmd_hi,
    input  logic [7:0]        mask_cmd_lo,
    output logic              poll_req,
    output logic [15:0]       poll_mask,
    input  logic              poll_done,
    input  logic [CNT_W-1:0]  poll_count,
    output logic              pkt_req,
    output logic [7:0]        pkt_type,
    output logic [7:0]        pkt_flag,
    output logic [CNT_W:0]    pkt_len,
    input  logic              pkt_ack
);
    logic              enable;
    logic              restart;
    logic              tick;
    logic              expire;
    logic [BYTE_W-1:0] reload;
    logic [MASK_W-1:0] mask;

    ap_config #(.DEF_PERIOD_MS(DEF_PERIOD_MS)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .en_cmd_vld(en_cmd_vld), .en_cmd_byte(en_cmd_byte),
        .rate_cmd_vld(rate_cmd_vld), .rate_cmd_byte(rate_cmd_byte),
        .mask_cmd_vld(mask_cmd_vld), .mask_cmd_hi(mask_cmd_hi), .mask_cmd_lo(mask_cmd_lo),
        .enable(enable), .restart(restart), .reload(reload), .mask(mask)
    );

    ap_ms_tick #(.CLK_PER_MS(CLK_PER_MS)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(enable), .restart(restart), .tick(tick)
    );

    ap_period_timer #(.DEF_PERIOD_MS(DEF_PERIOD_MS)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(enable), .restart(restart),
        .tick(tick), .reload(reload), .expire(expire)
    );

    ap_poll_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .expire(expire), .mask(mask),
        .poll_req(poll_req), .poll_mask(poll_mask),
        .poll_done(poll_done), .poll_count(poll_count),
        .pkt_req(pkt_req), .pkt_len(pkt_len), .pkt_ack(pkt_ack)
    );

    assign pkt_type = HDR_TYPE_POLLED;
    assign pkt_flag = HDR_FLAG_POLLED;
endmodule

// File: tb/autopoll_sched_bench.sv
// Directed bench for the autopoll scheduler; one task per scenario.
module autopoll_sched_bench;
    localparam int CLK_PERIOD = 10;
    localparam int K = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_cmd_vld = 1'b0;
    logic [7:0]  en_cmd_byte = '0;
    logic        rate_cmd_vld = 1'b0;
    logic [7:0]  rate_cmd_byte = '0;
    logic        mask_cmd_vld = 1'b0;
    logic [7:0]  mask_cmd_hi = '0;
    logic [7:0]  mask_cmd_lo = '0;
    logic        poll_req;
    logic [15:0] poll_mask;
    logic        poll_done = 1'b0;
    logic [7:0]  poll_count = '0;
    logic        pkt_req;
    logic [7:0]  pkt_type;
    logic [7:0]  pkt_flag;
    logic [8:0]  pkt_len;
    logic        pkt_ack;
    logic        ack_auto = 1'b0;
    logic        man_ack = 1'b0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int cmd_cyc = 0;
    int rises = 0;
    int last_rise = 0;
    logic [15:0] rise_mask = '0;
    logic prev_req = 1'b0;
    int pkts = 0;
    logic [7:0] rec_type = '0;
    logic [7:0] rec_flag = '0;
    logic [8:0] rec_len = '0;
    logic [7:0] resp_count = 8'd3;
    logic auto_ack = 1'b1;

    assign pkt_ack = ack_auto | man_ack;

    autopoll_sched #(.CLK_PER_MS(K), .DEF_PERIOD_MS(20), .CNT_W(8)) u_autopoll_sched (
        .clk(clk), .rst_n(rst_n),
        .en_cmd_vld(en_cmd_vld), .en_cmd_byte(en_cmd_byte),
        .rate_cmd_vld(rate_cmd_vld), .rate_cmd_byte(rate_cmd_byte),
        .mask_cmd_vld(mask_cmd_vld), .mask_cmd_hi(mask_cmd_hi), .mask_cmd_lo(mask_cmd_lo),
        .poll_req(poll_req), .poll_mask(poll_mask),
        .poll_done(poll_done), .poll_count(poll_count),
        .pkt_req(pkt_req), .pkt_type(pkt_type), .pkt_flag(pkt_flag),
        .pkt_len(pkt_len), .pkt_ack(pkt_ack)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor poll starts and answer the handshakes.
    always @(negedge clk) begin
        prev_req <= poll_req;
        if (poll_req && !prev_req) begin
            rises     <= rises + 1;
            last_rise <= cyc;
            rise_mask <= poll_mask;
        end
        if (poll_req && !poll_done) begin
            poll_done  <= 1'b1;
            poll_count <= resp_count;
        end else begin
            poll_done <= 1'b0;
        end
        if (auto_ack && pkt_req && !ack_auto) begin
            ack_auto <= 1'b1;
            pkts     <= pkts + 1;
            rec_type <= pkt_type;
            rec_flag <= pkt_flag;
            rec_len  <= pkt_len;
        end else begin
            ack_auto <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send_enable(input logic [7:0] b);
        @(negedge clk);
        en_cmd_vld = 1'b1; en_cmd_byte = b;
        @(negedge clk);
        en_cmd_vld = 1'b0;
        cmd_cyc = cyc;
    endtask

    task automatic send_rate(input logic [7:0] b);
        @(negedge clk);
        rate_cmd_vld = 1'b1; rate_cmd_byte = b;
        @(negedge clk);
        rate_cmd_vld = 1'b0;
        cmd_cyc = cyc;
    endtask

    task automatic send_mask(input logic [7:0] hi, input logic [7:0] lo);
        @(negedge clk);
        mask_cmd_vld = 1'b1; mask_cmd_hi = hi; mask_cmd_lo = lo;
        @(negedge clk);
        mask_cmd_vld = 1'b0;
    endtask

    task automatic wait_rise(input int max_cyc, input string req);
        int r0 = rises;
        int n = 0;
        while (rises == r0 && n < max_cyc) begin
            @(negedge clk);
            n++;
        end
        if (rises == r0) chk(1'b0, req, 0, 1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(poll_req == 1'b0, "R1", int'(poll_req), 0);
        chk(pkt_req == 1'b0, "R1", int'(pkt_req), 0);
        chk(poll_mask == 16'hFFFF, "R1", int'(poll_mask), 16'hFFFF);
        repeat (300) @(negedge clk);
        chk(rises == 0, "R1", rises, 0);
    endtask

    task automatic t_enable();
        int r;
        int p;
        resp_count = 8'd3;
        p = pkts;
        send_enable(8'h01);
        wait_rise(200, "R2");
        chk(last_rise - cmd_cyc == 20 * K, "R2", last_rise - cmd_cyc, 20 * K);
        chk(rise_mask == 16'hFFFF, "R1", int'(rise_mask), 16'hFFFF);
        repeat (6) @(negedge clk);
        chk(pkts == p + 1, "R8", pkts, p + 1);
        chk(rec_type == 8'h00, "R8", int'(rec_type), 0);
        chk(rec_flag == 8'h40, "R8", int'(rec_flag), 8'h40);
        chk(rec_len == 9'd5, "R8", int'(rec_len), 5);
        r = last_rise;
        wait_rise(200, "R10");
        chk(last_rise - r == 20 * K, "R10", last_rise - r, 20 * K);
    endtask

    task automatic t_reenable();
        int r = last_rise;
        repeat (30) @(negedge clk);
        send_enable(8'h7F);
        wait_rise(200, "R3");
        chk(last_rise - r == 20 * K, "R3", last_rise - r, 20 * K);
    endtask

    task automatic t_rate();
        int r;
        send_rate(8'd5);
        wait_rise(200, "R5");
        chk(last_rise - cmd_cyc == 5 * K, "R5", last_rise - cmd_cyc, 5 * K);
        r = last_rise;
        wait_rise(200, "R5");
        chk(last_rise - r == 5 * K, "R5", last_rise - r, 5 * K);
    endtask

    task automatic t_rate_zero();
        int r = last_rise;
        repeat (7) @(negedge clk);
        send_rate(8'd0);
        wait_rise(200, "R6");
        chk(last_rise - r == 5 * K, "R6", last_rise - r, 5 * K);
        r = last_rise;
        wait_rise(200, "R6");
        chk(last_rise - r == 5 * K, "R6", last_rise - r, 5 * K);
    endtask

    task automatic t_nodata();
        int p;
        int r;
        resp_count = 8'd0;
        wait_rise(200, "R9");
        p = pkts;
        r = last_rise;
        wait_rise(200, "R10");
        chk(last_rise - r == 5 * K, "R10", last_rise - r, 5 * K);
        repeat (5) @(negedge clk);
        chk(pkts == p, "R9", pkts, p);
        chk(pkt_req == 1'b0, "R9", int'(pkt_req), 0);
    endtask

    task automatic t_mask();
        send_mask(8'hAB, 8'hCD);
        wait_rise(200, "R7");
        chk(rise_mask == 16'hABCD, "R7", int'(rise_mask), 16'hABCD);
    endtask

    task automatic t_disable();
        int r0;
        repeat (3) @(negedge clk);
        send_enable(8'h00);
        r0 = rises;
        repeat (100) @(negedge clk);
        chk(rises == r0, "R4", rises - r0, 0);
        send_rate(8'd3);
        repeat (60) @(negedge clk);
        chk(rises == r0, "R5", rises - r0, 0);
        send_enable(8'h02);
        wait_rise(200, "R5");
        chk(last_rise - cmd_cyc == 3 * K, "R5", last_rise - cmd_cyc, 3 * K);
    endtask

    task automatic t_hold();
        int r;
        int r0;
        bit held = 1'b1;
        resp_count = 8'd2;
        auto_ack = 1'b0;
        wait_rise(200, "R8");
        r = last_rise;
        while (!pkt_req && cyc < r + 5) @(negedge clk);
        chk(pkt_req == 1'b1, "R8", int'(pkt_req), 1);
        chk(pkt_len == 9'd4, "R8", int'(pkt_len), 4);
        chk(pkt_flag == 8'h40, "R8", int'(pkt_flag), 8'h40);
        r0 = rises;
        while (cyc < r + 30) begin
            @(negedge clk);
            if (!pkt_req) held = 1'b0;
        end
        chk(held, "R8", int'(held), 1);
        chk(rises == r0, "R10", rises - r0, 0);
        man_ack = 1'b1;
        @(negedge clk);
        man_ack = 1'b0;
        chk(pkt_req == 1'b0, "R8", int'(pkt_req), 0);
        auto_ack = 1'b1;
        wait_rise(200, "R10");
        chk(last_rise - r == 9 * K, "R10", last_rise - r, 9 * K);
    endtask

    task automatic t_max_rate();
        resp_count = 8'd0;
        send_rate(8'd255);
        wait_rise(1200, "R5");
        chk(last_rise - cmd_cyc == 255 * K, "R5", last_rise - cmd_cyc, 255 * K);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        t_reset();
        t_enable();
        t_reenable();
        t_rate();
        t_rate_zero();
        t_nodata();
        t_mask();
        t_disable();
        t_hold();
        t_max_rate();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule